// File: doc/BRIEF.md
# Peripheral Interrupt Flag Bank with Sequenced Clear

This block holds a small set of interrupt flags for a peripheral, together with a matching register of per-flag enable bits and one data register. Hardware events set individual flags. A flag asks the processor for service only when its enable bit is one and the global interrupt mask input is low. While either condition is missing, the flag stays set and its request stays pending until it is allowed through or cleared.

Software can clear a flag in two ways. The first is to write the status register with a zero in that flag's bit position. A one in a bit position leaves that flag alone. The second is a two-step sequence: read the status register while the flag is set, then read or write the data register. Both methods remove the stored request. A request that was pending under the mask is therefore lost, and it does not fire when the mask is later lifted.

The register bus has a 2-bit address, a read strobe, a write strobe, write data and combinational read data. Address 0 selects status, address 1 selects control (the enables) and address 2 selects data.

Top module: `irqflag_bank`

## Requirements
- R1: While reset is asserted, every flag, every enable bit, every arming bit and the data register are zero, and the interrupt request output is low.
- R2: A one on bit i of the event input during a clock edge sets flag i. A read at address 0 returns the flags in bits [NUM_FLAGS-1:0] and zeros above them.
- R3: The request output is high exactly when some flag and its enable bit are both one and the mask input is low. A masked flag keeps its state and raises the request as soon as the mask drops.
- R4: A flag whose enable bit is zero does not drive the request, and it stays set.
- R5: A write at address 0 clears each flag whose write-data bit is zero. A flag whose write-data bit is one is left unchanged.
- R6: Each flag that a status read saw set is cleared by the next read or write at address 2. Flags set after that status read are not cleared.
- R7: An access at address 2 that no status read has armed clears no flag. An access also disarms, so a second data access clears nothing.
- R8: Every status read rearms from the flags it sees. A flag cleared by a status write after arming is no longer armed.
- R9: When a set event and either kind of clear hit the same flag in the same cycle, the flag ends up set.
- R10: Clearing a flag that is pending under the mask discards its request, so lowering the mask afterwards raises nothing.
- R11: A write at address 1 stores the enable bits from write-data bits [NUM_FLAGS-1:0], and a read there returns them. A write at address 2 stores the full data word, and a read there returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 2 | Register address: 0 status, 1 control, 2 data |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for the addressed register, combinational |
| setEvt | input | NUM_FLAGS | Per-flag hardware set events, one cycle each |
| iMask | input | 1 | Global interrupt mask, high blocks requests |
| irqReq | output | 1 | Interrupt request to the processor |

## Verification
Every register in the block updates on the rising edge that sees a strobe or an event. Read data and the request output are combinational from that state. The request also follows the mask input within the same cycle. As a result, the effect of a write, an event or a clear step can first be seen in the cycle after the edge that took it in, while a change of the mask can be seen in the cycle it is driven. The bench applies each vector at a falling edge and compares outputs 4 ns later, before the next rising edge. Each vector's expected values therefore reflect all previous vectors and the present mask, never the vector's own register effects.

// File: rtl/irqflag_pkg.sv
package irqflag_pkg;
  localparam int REG_ADDR_W = 2;
  localparam logic [REG_ADDR_W-1:0] ADDR_STAT = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_CTRL = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_DATA = 2'd2;

  typedef struct packed {
    logic statSel;
    logic ctrlSel;
    logic dataSel;
    logic statRd;
    logic statWr;
    logic ctrlWr;
    logic dataWr;
    logic dataAcc;
  } busStrobe_t;
endpackage

// File: rtl/irqflag_ctrl.sv
module irqflag_ctrl
  import irqflag_pkg::*;
(
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic                  busRd,
  input  logic                  busWr,
  output busStrobe_t            strb
);
  always_comb begin
    strb         = '0;
    strb.statSel = (busAddr == ADDR_STAT);
    strb.ctrlSel = (busAddr == ADDR_CTRL);
    strb.dataSel = (busAddr == ADDR_DATA);
    strb.statRd  = strb.statSel && busRd;
    strb.statWr  = strb.statSel && busWr;
    strb.ctrlWr  = strb.ctrlSel && busWr;
    strb.dataWr  = strb.dataSel && busWr;
    strb.dataAcc = strb.dataSel && (busRd || busWr);
  end
endmodule

// File: rtl/irqflag_dpath.sv
module irqflag_dpath
  import irqflag_pkg::*;
#(
  parameter int NUM_FLAGS = 4,
  parameter int DATA_W    = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  busStrobe_t           strb,
  input  logic [DATA_W-1:0]    busWdata,
  input  logic [NUM_FLAGS-1:0] setEvt,
  input  logic                 iMask,
  output logic [DATA_W-1:0]    busRdata,
  output logic                 irqReq,
  output logic [NUM_FLAGS-1:0] flagsQ
);
  logic [NUM_FLAGS-1:0] armedQ;
  logic [NUM_FLAGS-1:0] enQ;
  logic [DATA_W-1:0]    dataQ;
  logic [NUM_FLAGS-1:0] wrKeep;

  assign wrKeep = busWdata[NUM_FLAGS-1:0];

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : gFlag
    logic clrBit;
    // a status write with a zero, or a data access while armed, clears the bit
    assign clrBit = (strb.statWr && !wrKeep[i]) || (strb.dataAcc && armedQ[i]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flagsQ[i] <= 1'b0;
        armedQ[i] <= 1'b0;
      end else begin
        // the set event takes priority over any clear in the same cycle
        flagsQ[i] <= setEvt[i] || (flagsQ[i] && !clrBit);
        if (strb.statRd)       armedQ[i] <= flagsQ[i];
        else if (strb.dataAcc) armedQ[i] <= 1'b0;
        else if (clrBit)       armedQ[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ   <= '0;
      dataQ <= '0;
    end else begin
      if (strb.ctrlWr) enQ   <= busWdata[NUM_FLAGS-1:0];
      if (strb.dataWr) dataQ <= busWdata;
    end
  end

  always_comb begin
    busRdata = '0;
    if (strb.statSel)      busRdata = DATA_W'(flagsQ);
    else if (strb.ctrlSel) busRdata = DATA_W'(enQ);
    else if (strb.dataSel) busRdata = dataQ;
  end

  assign irqReq = (|(flagsQ & enQ)) && !iMask;
endmodule

// File: rtl/irqflag_bank.sv
module irqflag_bank
  import irqflag_pkg::*;
#(
  parameter int NUM_FLAGS = 4,
  parameter int DATA_W    = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic                  busRd,
  input  logic                  busWr,
  input  logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W-1:0]     busRdata,
  input  logic [NUM_FLAGS-1:0]  setEvt,
  input  logic                  iMask,
  output logic                  irqReq
);
  busStrobe_t           strb;
  logic [NUM_FLAGS-1:0] flagsQ;

  irqflag_ctrl uCtrl (
    .busAddr (busAddr),
    .busRd   (busRd),
    .busWr   (busWr),
    .strb    (strb)
  );

  irqflag_dpath #(
    .NUM_FLAGS (NUM_FLAGS),
    .DATA_W    (DATA_W)
  ) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busWdata (busWdata),
    .setEvt   (setEvt),
    .iMask    (iMask),
    .busRdata (busRdata),
    .irqReq   (irqReq),
    .flagsQ   (flagsQ)
  );
endmodule

// File: rtl/irqflag_chk.sv
module irqflag_chk
  import irqflag_pkg::*;
#(
  parameter int NUM_FLAGS = 4,
  parameter int DATA_W    = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [REG_ADDR_W-1:0] busAddr,
  input logic                  busRd,
  input logic                  busWr,
  input logic [DATA_W-1:0]     busWdata,
  input logic [NUM_FLAGS-1:0]  setEvt,
  input logic                  iMask,
  input logic                  irqReq,
  input logic [NUM_FLAGS-1:0]  flags
);
  logic statWrHit;
  logic dataHit;
  assign statWrHit = busWr && (busAddr == ADDR_STAT);
  assign dataHit   = (busRd || busWr) && (busAddr == ADDR_DATA);

  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_clear_R1: assert (flags == '0 && !irqReq)
        else $error("reset state not clear");
    end
  end

  assert_masked_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    iMask |-> !irqReq);

  assert_pending_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (setEvt == '0 && !statWrHit && !dataHit) |=> flags == $past(flags));

  assert_write_one_keeps_R5: assert property (@(posedge clk) disable iff (!rstN)
    (statWrHit && (&busWdata[NUM_FLAGS-1:0])) |=> ((flags & $past(flags)) == $past(flags)));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    (setEvt != '0) |=> ((flags & $past(setEvt)) == $past(setEvt)));
endmodule

bind irqflag_bank irqflag_chk #(
  .NUM_FLAGS (NUM_FLAGS),
  .DATA_W    (DATA_W)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busRd    (busRd),
  .busWr    (busWr),
  .busWdata (busWdata),
  .setEvt   (setEvt),
  .iMask    (iMask),
  .irqReq   (irqReq),
  .flags    (flagsQ)
);

// File: tb/tb_irqflag_bank.sv
`timescale 1ns/1ps
module tb_irqflag_bank;
  localparam int NF = 4;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    busAddr = '0;
  logic          busRd = 1'b0;
  logic          busWr = 1'b0;
  logic [DW-1:0] busWdata = '0;
  logic [DW-1:0] busRdata;
  logic [NF-1:0] setEvt = '0;
  logic          iMask = 1'b0;
  logic          irqReq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  irqflag_bank #(.NUM_FLAGS(NF), .DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .setEvt(setEvt), .iMask(iMask),
    .irqReq(irqReq)
  );

  typedef struct packed {
    logic [1:0]    a;
    logic          rd;
    logic          wr;
    logic [DW-1:0] wd;
    logic [NF-1:0] se;
    logic          im;
    logic          chk;
    logic [DW-1:0] expRd;
    logic          expIrq;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 30;
  // fields: addr, rd, wr, wdata, setEvt, mask, checkRd, expRd, expIrq, req
  localparam vec_t TBL [NV] = '{
    '{2'd1,1'b0,1'b1,8'h0F,4'h0,1'b0,1'b0,8'h00,1'b0,4'd11}, // R11 enable all
    '{2'd0,1'b0,1'b0,8'h00,4'h1,1'b1,1'b0,8'h00,1'b0,4'd2},  // R2 set flag0 masked
    '{2'd0,1'b1,1'b0,8'h00,4'h0,1'b1,1'b1,8'h01,1'b0,4'd3},  // R3 masked pending, arms
    '{2'd0,1'b0,1'b0,8'h00,4'h0,1'b0,1'b0,8'h00,1'b1,4'd3},  // R3 mask drops
    '{2'd2,1'b1,1'b0,8'h00,4'h0,1'b1,1'b1,8'h00,1'b0,4'd6},  // R6 data read clears
    '{2'd0,1'b1,1'b0,8'h00,4'h0,1'b0,1'b1,8'h00,1'b0,4'd10}, // R10 request lost
    '{2'd0,1'b0,1'b0,8'h00,4'h2,1'b0,1'b0,8'h00,1'b0,4'd2},  // R2 set flag1
    '{2'd2,1'b1,1'b0,8'h00,4'h0,1'b0,1'b1,8'h00,1'b1,4'd7},  // R7 unarmed access
    '{2'd0,1'b1,1'b0,8'h00,4'h0,1'b0,1'b1,8'h02,1'b1,4'd7},  // R7 flag1 kept
    '{2'd2,1'b0,1'b1,8'h5A,4'h4,1'b0,1'b0,8'h00,1'b1,4'd6},  // R6 data write clears
    '{2'd2,1'b1,1'b0,8'h00,4'h0,1'b0,1'b1,8'h5A,1'b1,4'd11}, // R11 data readback
    '{2'd0,1'b1,1'b0,8'h00,4'h0,1'b0,1'b1,8'h04,1'b1,4'd6},  // R6 late flag2 kept
    '{2'd1,1'b0,1'b1,8'h0B,4'h0,1'b0,1'b0,8'h00,1'b1,4'd4},  // R4 disable flag2
    '{2'd0,1'b1,1'b0,8'h00,4'h0,1'b0,1'b1,8'h04,1'b0,4'd4},  // R4 no request
    '{2'd2,1'b1,1'b0,8'h00,4'h4,1'b0,1'b1,8'h5A,1'b0,4'd9},  // R9 set vs seq clear
    '{2'd0,1'b1,1'b0,8'h00,4'h0,1'b0,1'b1,8'h04,1'b0,4'd9},  // R9 flag2 still set
    '{2'd0,1'b0,1'b1,8'hFF,4'h1,1'b0,1'b0,8'h00,1'b0,4'd5},  // R5 write ones
    '{2'd0,1'b1,1'b0,8'h00,4'h0,1'b0,1'b1,8'h05,1'b1,4'd5},  // R5 nothing cleared
    '{2'd0,1'b0,1'b1,8'hFE,4'h0,1'b0,1'b0,8'h00,1'b1,4'd5},  // R5 clear flag0
    '{2'd1,1'b1,1'b0,8'h00,4'h0,1'b0,1'b1,8'h0B,1'b0,4'd11}, // R11 control readback
    '{2'd0,1'b0,1'b1,8'hFB,4'h4,1'b0,1'b0,8'h00,1'b0,4'd9},  // R9 set vs write zero
    '{2'd0,1'b1,1'b0,8'h00,4'h0,1'b0,1'b1,8'h04,1'b0,4'd9},  // R9 flag2 still set
    '{2'd0,1'b0,1'b1,8'h00,4'h0,1'b0,1'b0,8'h00,1'b0,4'd5},  // R5 clear all
    '{2'd0,1'b1,1'b0,8'h00,4'h0,1'b0,1'b1,8'h00,1'b0,4'd5},  // R5 empty
    '{2'd0,1'b0,1'b0,8'h00,4'h1,1'b0,1'b0,8'h00,1'b0,4'd2},  // R2 set flag0
    '{2'd0,1'b1,1'b0,8'h00,4'h0,1'b0,1'b1,8'h01,1'b1,4'd8},  // R8 arm flag0
    '{2'd0,1'b0,1'b1,8'hFE,4'h0,1'b0,1'b0,8'h00,1'b1,4'd8},  // R8 write clear disarms
    '{2'd0,1'b0,1'b0,8'h00,4'h1,1'b0,1'b0,8'h00,1'b0,4'd8},  // R8 set again
    '{2'd2,1'b1,1'b0,8'h00,4'h0,1'b0,1'b1,8'h5A,1'b1,4'd8},  // R8 not armed
    '{2'd0,1'b1,1'b0,8'h00,4'h0,1'b0,1'b1,8'h01,1'b1,4'd8}   // R8 flag0 survives
  };

  task automatic checkVal(input string tag, input logic [DW-1:0] act,
                          input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] a, input logic rd, input logic wr,
                       input logic [DW-1:0] wd, input logic [NF-1:0] se,
                       input logic im);
    busAddr = a; busRd = rd; busWr = wr; busWdata = wd; setEvt = se; iMask = im;
  endtask

  initial begin
    #100us;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state observed through the bus
    @(negedge clk);
    drive(2'd0, 1'b1, 1'b0, '0, '0, 1'b0);
    #4;
    checkVal("R1 status", busRdata, 8'h00);
    checkVal("R1 irq", {7'd0, irqReq}, 8'h00);
    busAddr = 2'd1; #0.5;
    checkVal("R1 control", busRdata, 8'h00);
    busAddr = 2'd2; #0.5;
    checkVal("R1 data", busRdata, 8'h00);
    @(negedge clk);
    rstN = 1'b1;
    drive(2'd0, 1'b0, 1'b0, '0, '0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TBL[i].a, TBL[i].rd, TBL[i].wr, TBL[i].wd, TBL[i].se, TBL[i].im);
      #4;
      checks++;
      if (irqReq !== TBL[i].expIrq) begin
        errors++;
        $display("FAIL R%0d vec %0d irq actual %b expected %b",
                 TBL[i].req, i, irqReq, TBL[i].expIrq);
      end
      if (TBL[i].chk) begin
        checks++;
        if (busRdata !== TBL[i].expRd) begin
          errors++;
          $display("FAIL R%0d vec %0d rdata actual %h expected %h",
                   TBL[i].req, i, busRdata, TBL[i].expRd);
        end
      end
    end

    // R1 reset in mid-run wipes flags, enables and data
    @(negedge clk);
    drive(2'd0, 1'b0, 1'b0, '0, 4'hF, 1'b0);
    @(negedge clk);
    drive(2'd0, 1'b1, 1'b0, '0, '0, 1'b0);
    #4;
    checkVal("R2 all set", busRdata, 8'h0F);
    rstN = 1'b0;
    #0.5;
    checkVal("R1 status after reset", busRdata, 8'h00);
    checkVal("R1 irq after reset", {7'd0, irqReq}, 8'h00);
    busAddr = 2'd1; #0.5;
    checkVal("R1 control after reset", busRdata, 8'h00);
    busAddr = 2'd2; #0.5;
    checkVal("R1 data after reset", busRdata, 8'h00);
    @(negedge clk);
    rstN = 1'b1;
    drive(2'd0, 1'b0, 1'b0, '0, '0, 1'b0);
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule